// File: doc/BRIEF.md
# Serial PHY Reset and Receive-PLL Lock Sequencer

This block drives the bring-up of a serial PHY whose registers sit behind an indirect access path. On a start request it sends commands to a separate handshake master. The first two commands address the PHY clock and reset register and then write its reset bit. The PHY cannot acknowledge that write in the normal way, so the block does not expect a reply from the PHY itself. It waits a fixed settle interval and then polls the lane output status register. Each poll is an address command followed by a read command. The sequence ends with success when the receive-PLL lock bit is set. It ends with an error when the retry budget is used up, or at once when the handshake master reports a timeout.

The handshake master is outside this block. It sees `cmd_valid_o` together with an operation and an operand, which stay constant until it returns a single-cycle `cmd_done_i` or `cmd_timeout_i`. For debug, the block reports the data of the last completed read and the number of poll attempts used. A separate sticky output requests PHY test power-down when the system finds that no device is attached.

Top module: `phy_rst_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `pdown_o` and `cmd_valid_o` are 0, and `poll_cnt_o` and `last_rdata_o` are 0.
- R2: An accepted start first issues an address command (op 0) with operand 0x7F3F, then a write command (op 1) with operand 0x0001. No cycles pass between the two. Op and operand stay stable while `cmd_valid_o` waits for a response.
- R3: Before every poll, including the first, `cmd_valid_o` stays low for exactly SETTLE_CYC cycles (default 100), counted from the response that ended the previous command.
- R4: Each poll is an address command (op 0) with operand 0x2003, followed at once by a read command (op 2) with operand 0. A read whose data has bit 1 set ends the sequence with `err_o`=0.
- R5: If MAX_POLLS polls (default 10) complete without lock, the sequence ends with `err_o`=1. In that case `poll_cnt_o` equals MAX_POLLS. Lock seen on the last allowed poll still counts as success.
- R6: `cmd_timeout_i` during any command ends the sequence in the next cycle with `err_o`=1, and no further command is issued.
- R7: `done_o` is a one-cycle pulse at the end of every sequence, and `busy_o` is low in that cycle. `err_o` keeps its value until the next accepted start, which clears it.
- R8: `start_i` while `busy_o` is high is ignored, and the command stream goes on unchanged.
- R9: A `pdown_req_i` pulse sets `pdown_o` in the next cycle. `pdown_o` then stays set until `rst_ni` is asserted. The request has no effect on the sequence.
- R10: `poll_cnt_o` counts the polls started since the last start. `last_rdata_o` holds the data of the last completed read, and an accepted start clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| pdown_req_i | input | 1 | Request PHY test power-down (no device present) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last sequence failed (retry exhaustion or command timeout) |
| pdown_o | output | 1 | Sticky test power-down control bit |
| cmd_valid_o | output | 1 | Command request to handshake master |
| cmd_op_o | output | 2 | Operation: 0 address, 1 write, 2 read |
| cmd_data_o | output | DATA_W | Register address or write value |
| cmd_done_i | input | 1 | Command completed |
| cmd_timeout_i | input | 1 | Command timed out in handshake master |
| cmd_rdata_i | input | DATA_W | Read data, valid with `cmd_done_i` on a read |
| last_rdata_o | output | DATA_W | Data of the last completed read |
| poll_cnt_o | output | $clog2(MAX_POLLS+1) | Poll attempts used |

## Verification
A command becomes visible on `cmd_valid_o` in the cycle after the state change that causes it. Busy and a cleared error appear in the cycle after the start is accepted. The done pulse, the error flag, the poll count and the last read data all appear in the cycle after the response that ends the sequence. The bench drives stimulus on falling edges and samples on the next falling edge, one register stage later. The modelled handshake master counts idle falling edges between commands and compares the count before each poll address against SETTLE_CYC exactly. It takes the expected command stream from a queue that the driver computes from the lock position and the timeout position. Final outputs are compared on the falling edge where `done_o` is seen, and again one edge later to confirm that the pulse ended and the error flag held.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } phy_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_ADDR,
    ST_RST_WR,
    ST_SETTLE,
    ST_POLL_ADDR,
    ST_POLL_RD
  } seq_state_e;

  localparam logic [15:0] CLK_RST_REG   = 16'h7F3F;
  localparam logic [15:0] RST_WR_VAL    = 16'h0001;
  localparam logic [15:0] LANE_STAT_REG = 16'h2003;
  localparam int          LOCK_BIT      = 1;
endpackage

// File: rtl/phy_rst_settle.sv
module phy_rst_settle #(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == '0);

  assert_settle_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);
  assert_settle_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/phy_rst_poll_ctr.sv
module phy_rst_poll_ctr #(
  parameter int MAX_POLLS = 10,
  localparam int CNT_W = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_W'(MAX_POLLS));

  assert_poll_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
endmodule

// File: rtl/phy_rst_pdown.sv
module phy_rst_pdown (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pdown_o
);
  logic pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pd_q <= 1'b0;
    else if (req_i) pd_q <= 1'b1;
  end

  assign pdown_o = pd_q;

  assert_pdown_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_o |=> pdown_o);
  assert_pdown_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> pdown_o);
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
  import phy_rst_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETTLE_CYC = 100,
  parameter int MAX_POLLS  = 10,
  localparam int POLL_W    = $clog2(MAX_POLLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pdown_req_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              pdown_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic              cmd_done_i,
  input  logic              cmd_timeout_i,
  input  logic [DATA_W-1:0] cmd_rdata_i,
  output logic [DATA_W-1:0] last_rdata_o,
  output logic [POLL_W-1:0] poll_cnt_o
);
  localparam int GAP_W = $clog2(SETTLE_CYC + 2);

  seq_state_e  state_q, state_d;
  logic        done_q, err_q;
  logic [DATA_W-1:0] rdata_q;
  logic        accept, cmd_ok, cmd_to;
  logic        fin_ok, fin_err, load_settle, settle_exp, poll_last;
  logic [POLL_W-1:0] poll_cnt;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign cmd_to = cmd_valid_o && cmd_timeout_i;
  assign cmd_ok = cmd_valid_o && cmd_done_i && !cmd_timeout_i;

  always_comb begin
    state_d     = state_q;
    fin_ok      = 1'b0;
    fin_err     = 1'b0;
    load_settle = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_RST_ADDR;
      ST_RST_ADDR:  if (cmd_ok) state_d = ST_RST_WR;
      ST_RST_WR:    if (cmd_ok) begin
                      state_d     = ST_SETTLE;
                      load_settle = 1'b1;
                    end
      ST_SETTLE:    if (settle_exp) state_d = ST_POLL_ADDR;
      ST_POLL_ADDR: if (cmd_ok) state_d = ST_POLL_RD;
      ST_POLL_RD:   if (cmd_ok) begin
                      if (cmd_rdata_i[LOCK_BIT]) begin
                        state_d = ST_IDLE;
                        fin_ok  = 1'b1;
                      end else if (poll_last) begin
                        state_d = ST_IDLE;
                        fin_err = 1'b1;
                      end else begin
                        state_d     = ST_SETTLE;
                        load_settle = 1'b1;
                      end
                    end
      default:      state_d = ST_IDLE;
    endcase
    // handshake timeout wins over everything
    if (cmd_to) begin
      state_d     = ST_IDLE;
      fin_ok      = 1'b0;
      fin_err     = 1'b1;
      load_settle = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok || fin_err;
      if (accept)       err_q <= 1'b0;
      else if (fin_err) err_q <= 1'b1;
      else if (fin_ok)  err_q <= 1'b0;
      if (accept) rdata_q <= '0;
      else if (cmd_ok && state_q == ST_POLL_RD) rdata_q <= cmd_rdata_i;
    end
  end

  always_comb begin
    cmd_valid_o = 1'b1;
    cmd_op_o    = OP_ADDR;
    cmd_data_o  = '0;
    unique case (state_q)
      ST_RST_ADDR:  cmd_data_o = DATA_W'(CLK_RST_REG);
      ST_RST_WR:    begin cmd_op_o = OP_WRITE; cmd_data_o = DATA_W'(RST_WR_VAL); end
      ST_POLL_ADDR: cmd_data_o = DATA_W'(LANE_STAT_REG);
      ST_POLL_RD:   cmd_op_o = OP_READ;
      default:      cmd_valid_o = 1'b0;
    endcase
  end

  phy_rst_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_settle),
    .run_i    (state_q == ST_SETTLE),
    .expire_o (settle_exp)
  );

  phy_rst_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (state_q == ST_SETTLE && settle_exp),
    .cnt_o  (poll_cnt),
    .last_o (poll_last)
  );

  phy_rst_pdown u_pdown (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (pdown_req_i),
    .pdown_o (pdown_o)
  );

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign last_rdata_o = rdata_q;
  assign poll_cnt_o   = poll_cnt;

  // idle-gap counter for the settle check
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           gap_q <= '0;
    else if (cmd_valid_o)                  gap_q <= '0;
    else if (gap_q != GAP_W'(SETTLE_CYC + 1)) gap_q <= gap_q + 1'b1;
  end

  assert_settle_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cmd_valid_o) && cmd_data_o == DATA_W'(LANE_STAT_REG)) |-> gap_q == GAP_W'(SETTLE_CYC));
  assert_cmd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_done_i && !cmd_timeout_i) |=>
      (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o)));
  assert_lock_ok_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_READ && cmd_done_i && !cmd_timeout_i && cmd_rdata_i[LOCK_BIT])
      |=> (done_o && !err_o && !busy_o));
  assert_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_timeout_i) |=> (done_o && err_o && !busy_o));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i || busy_o) |=> (done_o || $stable(err_o)));
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !cmd_to && !fin_ok && !fin_err) |=> busy_o);
endmodule

// File: tb/phy_rst_seq_test.sv
`timescale 1ns/1ps
module phy_rst_seq_test;
  localparam int DATA_W = 16;
  localparam int SETTLE = 100;
  localparam int MAXP   = 10;
  localparam int PW     = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pd_req = 1'b0;
  logic busy, done, err, pdown, cvalid;
  logic [1:0] cop;
  logic [DATA_W-1:0] cdata, last_rd;
  logic cdone = 1'b0, cto = 1'b0;
  logic [DATA_W-1:0] crdata = '0;
  logic [PW-1:0] pcnt;

  always #2.5 clk = ~clk;

  phy_rst_seq #(.DATA_W(DATA_W), .SETTLE_CYC(SETTLE), .MAX_POLLS(MAXP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pdown_req_i(pd_req),
    .busy_o(busy), .done_o(done), .err_o(err), .pdown_o(pdown),
    .cmd_valid_o(cvalid), .cmd_op_o(cop), .cmd_data_o(cdata),
    .cmd_done_i(cdone), .cmd_timeout_i(cto), .cmd_rdata_i(crdata),
    .last_rdata_o(last_rd), .poll_cnt_o(pcnt));

  int checks = 0, errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scenario knobs for the modelled handshake master
  int lock_at = 0, to_idx = -1, lat = 1;
  int cmd_idx = 0, poll_idx = 0, wait_cnt = 0, gap = 0;
  bit resp_now = 0;
  logic [1:0]        q_op[$];
  logic [DATA_W-1:0] q_dat[$];

  function automatic logic [DATA_W-1:0] rd_val(input int p);
    if (p == lock_at) return 16'h0002 | DATA_W'(p << 8);
    return 16'h5A00 | DATA_W'(p << 4);
  endfunction

  // monitor + handshake master
  always @(negedge clk) begin
    if (resp_now) begin
      cdone <= 1'b0; cto <= 1'b0; resp_now = 0; wait_cnt = 0;
    end
    if (!cvalid) begin
      gap++;
    end else if (!resp_now && cdone == 1'b0 && cto == 1'b0) begin
      if (wait_cnt == 0 && q_dat.size() > 0 && q_dat[0] == 16'h2003 && q_op[0] == 2'd0)
        chk(gap == SETTLE, "R3 settle gap", gap, SETTLE);
      gap = 0;
      wait_cnt++;
      if (wait_cnt >= lat) begin
        if (q_op.size() == 0) begin
          chk(0, "R6 unexpected command", int'(cdata), -1);
        end else begin
          logic [1:0] eo; logic [DATA_W-1:0] ed;
          eo = q_op.pop_front(); ed = q_dat.pop_front();
          chk(cop == eo, "R2 R4 cmd op", cop, eo);
          chk(cdata == ed, "R2 R4 cmd operand", cdata, ed);
        end
        if (cop == 2'd2) begin
          poll_idx++;
          crdata <= rd_val(poll_idx);
        end
        if (cmd_idx == to_idx) cto <= 1'b1; else cdone <= 1'b1;
        cmd_idx++;
        resp_now = 1;
      end
    end
  end

  task automatic run_seq(input int lk, input int toi, input int l, input bit inj_start, input bit inj_pd);
    int n, total, polls, reads;
    bit exp_err, prev_err;
    logic [DATA_W-1:0] exp_last;
    lock_at = lk; to_idx = toi; lat = l; cmd_idx = 0; poll_idx = 0;
    n = (lk >= 1 && lk <= MAXP) ? lk : MAXP;
    total = 2 + 2 * n;
    q_op.delete(); q_dat.delete();
    for (int i = 0; i < total; i++) begin
      if (toi >= 0 && i > toi) break;
      if (i == 0)          begin q_op.push_back(2'd0); q_dat.push_back(16'h7F3F); end
      else if (i == 1)     begin q_op.push_back(2'd1); q_dat.push_back(16'h0001); end
      else if (i % 2 == 0) begin q_op.push_back(2'd0); q_dat.push_back(16'h2003); end
      else                 begin q_op.push_back(2'd2); q_dat.push_back(16'h0000); end
    end
    if (toi >= 0 && toi < total) begin
      exp_err = 1;
      polls = (toi >= 2) ? (toi - 2) / 2 + 1 : 0;
      reads = (toi >= 4) ? (toi - 4) / 2 + 1 : 0;
    end else begin
      exp_err = !(lk >= 1 && lk <= MAXP);
      polls = n; reads = n;
    end
    exp_last = (reads == 0) ? '0 : rd_val(reads);

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    chk(err == 1'b0, "R7 err cleared by start", err, 0);
    chk(last_rd == '0, "R10 last data cleared", last_rd, 0);
    if (inj_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;            // R8: busy start must be ignored
      @(negedge clk); start = 1'b0;
    end
    if (inj_pd) begin
      @(negedge clk); pd_req = 1'b1;
      @(negedge clk); pd_req = 1'b0;
      chk(pdown == 1'b1, "R9 pdown set", pdown, 1);
    end
    while (!done) @(negedge clk);
    chk(err == exp_err, "R4 R5 R6 err at done", err, exp_err);
    chk(busy == 1'b0, "R7 idle at done", busy, 0);
    chk(pcnt == PW'(polls), "R5 R10 poll count", pcnt, polls);
    chk(last_rd == exp_last, "R10 last read data", last_rd, exp_last);
    chk(q_op.size() == 0, "R6 R8 commands remaining", q_op.size(), 0);
    prev_err = err;
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(err == prev_err, "R7 err held", err, prev_err);
    repeat (4) @(negedge clk);
    chk(cvalid == 1'b0, "R6 no command after end", cvalid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R1 reset status", {busy, done, err}, 0);
    chk(pdown == 0 && cvalid == 0, "R1 reset pdown/cmd", {pdown, cvalid}, 0);
    chk(pcnt == 0 && last_rd == 0, "R1 reset debug", pcnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_seq(1, -1, 1, 0, 0);    // R4 quick lock
    run_seq(4, -1, 3, 1, 1);    // R8 busy start, R9 pdown
    run_seq(0, -1, 2, 0, 0);    // R5 never locks
    run_seq(3, 1, 2, 0, 0);     // R6 timeout on reset write
    run_seq(6, 5, 1, 0, 0);     // R6 timeout on second read
    run_seq(MAXP, -1, 1, 0, 0); // R5 lock on last attempt
    chk(pdown == 1'b1, "R9 pdown sticky", pdown, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(pdown == 1'b0, "R9 pdown cleared by reset", pdown, 0);
    rst_n = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule